// File: doc/BRIEF.md
# Cascaded Programmable Interrupt Controller

This block collects fifteen edge-triggered interrupt request lines into a single interrupt towards the processor. Internally it is built from two eight-line controller units. The secondary unit's request output is wired into line 2 of the primary unit. Each unit records rising edges as pending requests and masks its lines one by one. When a request is accepted, it marks that line as being serviced. A programmable base value is added to the line number to form the 8-bit vector.

The interrupt is offered on a valid/ready channel. `vec_valid` is the interrupt request and `vec_data` carries the vector. The processor accepts it by raising `vec_ready`, and the accepting cycle moves the chosen pending line into service. Once `vec_valid` is high it stays high until it is accepted. Only a mask write that blocks the chosen line can withdraw it. `vec_data` always shows the highest-priority line at the moment of acceptance, so a higher-priority edge that arrives while the processor holds `vec_ready` low replaces it.

Software uses a small register window. `reg_sel` picks the unit (0 primary, 1 secondary) and `reg_addr` picks the register. Software writes the masks, writes the base values and signals end-of-service with an acknowledge write. The window also reads back the pending and in-service sets. An interrupt from the secondary unit has to be acknowledged at both units before delivery resumes.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset, both masks read 0xFF, the pending and in-service sets of both units read 0x00, and `vec_valid` is low.
- R2: A rising edge on a request line sets that line's pending bit whether or not the line is masked. A line whose mask bit is 1 never causes `vec_valid`.
- R3: Within a unit, the lowest-numbered unmasked pending line wins. In the primary unit, cascade line 2 therefore ranks below lines 0 and 1 and above lines 3 to 7.
- R4: The vector is the unit's base value plus the line number, modulo 256. A request from the secondary unit carries the secondary base plus the secondary line.
- R5: No interrupt is offered until the base values of both units have been written after reset.
- R6: A cycle with `vec_valid` and `vec_ready` both high moves the chosen pending bit into service. `vec_valid` is low in the following cycle, and a unit with a bit in service offers nothing until that bit is acknowledged.
- R7: Writing any value to register 2 of a unit clears the highest-priority in-service bit of that unit.
- R8: An accepted secondary request sets primary in-service bit 2 and the secondary in-service bit. No interrupt is offered until both units have been acknowledged.
- R9: The register map is: 0 mask (read/write), 1 base value (read/write), 2 acknowledge (write only, reads 0), 3 pending (read), 4 in-service (read). Primary pending bit 2 reads the current request level of the secondary unit.
- R10: Request pins map as follows. `irq_req[1:0]` drive primary lines 0 and 1, `irq_req[6:2]` drive primary lines 3 to 7, and `irq_req[14:7]` drive secondary lines 0 to 7.
- R11: While `vec_ready` is low and no mask is written, `vec_valid` stays high once raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 15 | Edge-triggered request lines |
| vec_valid | output | 1 | Interrupt offered to the processor |
| vec_ready | input | 1 | Processor accepts the offered vector |
| vec_data | output | 8 | Vector of the offered interrupt |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Unit select: 0 primary, 1 secondary |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |

## Verification
The bench uses the default parameters: eight lines per unit, cascade on primary line 2 and 8-bit vectors. With these values every line of both units, and the full interplay of primary and secondary, can be reached through the fifteen pins. Base values of 32 and 40 make each vector identify its unit and line directly. The cascade at line 2 lets primary lines 0 and 1 outrank secondary requests while lines 3 to 7 rank below them.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam logic [2:0] RA_MASK = 3'd0;
  localparam logic [2:0] RA_BASE = 3'd1;
  localparam logic [2:0] RA_ACK  = 3'd2;
  localparam logic [2:0] RA_PEND = 3'd3;
  localparam logic [2:0] RA_INSV = 3'd4;
endpackage

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int N  = 8,
  parameter int LW = 3
) (
  input  logic [N-1:0]  cand,
  output logic          any,
  output logic [LW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) idx = LW'(i);
    end
  end
  assign any = |cand;
endmodule

// File: rtl/irqc_unit.sv
module irqc_unit #(
  parameter int             N           = 8,
  parameter int             DW          = 8,
  parameter int             LW          = 3,
  parameter logic [N-1:0]   LEVEL_LINES = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          enable,
  input  logic          take,
  input  logic          mask_we,
  input  logic          base_we,
  input  logic          ack_we,
  input  logic [DW-1:0] wdata,
  output logic          out_req,
  output logic [LW-1:0] pick,
  output logic [DW-1:0] vec,
  output logic [N-1:0]  mask_o,
  output logic [DW-1:0] base_o,
  output logic [N-1:0]  pend_o,
  output logic [N-1:0]  isr_o,
  output logic          base_ok
);
  logic [N-1:0]  req_eff;
  logic [N-1:0]  mask_q, isr_q, isr_nxt;
  logic [DW-1:0] base_q;
  logic          base_ok_q;
  logic          any;

  // per-line capture: level lines pass straight through, others latch a rising edge
  for (genvar i = 0; i < N; i++) begin : g_line
    if (LEVEL_LINES[i]) begin : g_lvl
      assign req_eff[i] = req[i];
    end else begin : g_edge
      logic r_q, p_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          r_q <= 1'b0;
          p_q <= 1'b0;
        end else begin
          r_q <= req[i];
          p_q <= (p_q & ~(take && pick == LW'(i))) | (req[i] & ~r_q);
        end
      end
      assign req_eff[i] = p_q;
    end
  end

  irqc_prio #(.N(N), .LW(LW)) u_prio (
    .cand (req_eff & ~mask_q),
    .any  (any),
    .idx  (pick)
  );

  assign out_req = enable & ~(|isr_q) & any;
  assign vec     = base_q + DW'(pick);

  always_comb begin
    isr_nxt = isr_q;
    if (ack_we) isr_nxt = isr_q & (isr_q - 1'b1);
    if (take)   isr_nxt = isr_nxt | (N'(1) << pick);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q    <= '1;
      isr_q     <= '0;
      base_q    <= '0;
      base_ok_q <= 1'b0;
    end else begin
      isr_q <= isr_nxt;
      if (mask_we) mask_q <= wdata[N-1:0];
      if (base_we) begin
        base_q    <= wdata;
        base_ok_q <= 1'b1;
      end
    end
  end

  assign mask_o  = mask_q;
  assign base_o  = base_q;
  assign pend_o  = req_eff;
  assign isr_o   = isr_q;
  assign base_ok = base_ok_q;

  a_r6_take_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !out_req);
  a_r6_single_service: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(isr_q));
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_we && !take) |=> (isr_q == '0));
  a_r5_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !out_req);
  a_r2_mask_honoured: assert property (@(posedge clk) disable iff (!rst_n)
    out_req |-> !mask_q[pick]);
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl #(
  parameter int N         = 8,
  parameter int DW        = 8,
  parameter int CASC_LINE = 2,
  localparam int LW       = $clog2(N),
  localparam int NREQ     = 2 * N - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] irq_req,
  output logic            vec_valid,
  input  logic            vec_ready,
  output logic [DW-1:0]   vec_data,
  input  logic            reg_we,
  input  logic            reg_sel,
  input  logic [2:0]      reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata
);
  import irqc_pkg::*;

  localparam logic [N-1:0] CASC_MASK = N'(1) << CASC_LINE;

  logic [N-1:0]  m_req, s_req;
  logic          m_out, s_out, m_take, s_take, armed;
  logic [LW-1:0] m_pick, s_pick;
  logic [DW-1:0] m_vec, s_vec, m_base, s_base;
  logic [N-1:0]  m_mask, s_mask, m_pend, s_pend, m_isr, s_isr;
  logic          m_ok, s_ok;
  logic          wr_m, wr_s;

  always_comb begin
    int k;
    k = 0;
    for (int i = 0; i < N; i++) begin
      if (i == CASC_LINE) begin
        m_req[i] = s_out;
      end else begin
        m_req[i] = irq_req[k];
        k++;
      end
    end
  end
  assign s_req = irq_req[NREQ-1:N-1];

  assign armed  = m_ok & s_ok;
  assign m_take = vec_valid & vec_ready;
  assign s_take = m_take & (m_pick == LW'(CASC_LINE));
  assign wr_m   = reg_we & ~reg_sel;
  assign wr_s   = reg_we & reg_sel;

  irqc_unit #(.N(N), .DW(DW), .LW(LW), .LEVEL_LINES(CASC_MASK)) u_primary (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (m_req),
    .enable  (armed & ~(|s_isr)),
    .take    (m_take),
    .mask_we (wr_m && reg_addr == RA_MASK),
    .base_we (wr_m && reg_addr == RA_BASE),
    .ack_we  (wr_m && reg_addr == RA_ACK),
    .wdata   (reg_wdata),
    .out_req (m_out),
    .pick    (m_pick),
    .vec     (m_vec),
    .mask_o  (m_mask),
    .base_o  (m_base),
    .pend_o  (m_pend),
    .isr_o   (m_isr),
    .base_ok (m_ok)
  );

  irqc_unit #(.N(N), .DW(DW), .LW(LW), .LEVEL_LINES('0)) u_secondary (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (s_req),
    .enable  (armed),
    .take    (s_take),
    .mask_we (wr_s && reg_addr == RA_MASK),
    .base_we (wr_s && reg_addr == RA_BASE),
    .ack_we  (wr_s && reg_addr == RA_ACK),
    .wdata   (reg_wdata),
    .out_req (s_out),
    .pick    (s_pick),
    .vec     (s_vec),
    .mask_o  (s_mask),
    .base_o  (s_base),
    .pend_o  (s_pend),
    .isr_o   (s_isr),
    .base_ok (s_ok)
  );

  assign vec_valid = m_out;
  assign vec_data  = (m_pick == LW'(CASC_LINE)) ? s_vec : m_vec;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_MASK: reg_rdata = DW'(reg_sel ? s_mask : m_mask);
      RA_BASE: reg_rdata = reg_sel ? s_base : m_base;
      RA_PEND: reg_rdata = DW'(reg_sel ? s_pend : m_pend);
      RA_INSV: reg_rdata = DW'(reg_sel ? s_isr : m_isr);
      default: reg_rdata = '0;
    endcase
  end

  a_r8_cascade_source: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && m_pick == LW'(CASC_LINE)) |-> s_out);
  a_r8_secondary_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (|s_isr) |-> !vec_valid);
  a_r11_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ready && !(reg_we && reg_addr == RA_MASK)) |=> vec_valid);
endmodule

// File: tb/cascade_irq_ctrl_bench.sv
module cascade_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] irq_req = '0;
  logic        vec_valid, vec_ready = 1'b0;
  logic [7:0]  vec_data;
  logic        reg_we = 1'b0, reg_sel = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0, reg_rdata;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cascade_irq_ctrl u_cascade_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .vec_valid(vec_valid),
    .vec_ready(vec_ready), .vec_data(vec_data), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  // {secondary flag, pin index, expected vector}; bases 32 / 40
  localparam logic [16:0] TBL [8] = '{
    {1'b0, 8'd0,  8'd32}, {1'b0, 8'd1,  8'd33}, {1'b0, 8'd2,  8'd35},
    {1'b0, 8'd4,  8'd37}, {1'b0, 8'd6,  8'd39}, {1'b1, 8'd7,  8'd40},
    {1'b1, 8'd10, 8'd43}, {1'b1, 8'd14, 8'd47}
  };

  task automatic chk(string rq, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", rq, got, exp);
    end
  endtask

  task automatic wr(logic sel, logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic sel, logic [2:0] a, output logic [7:0] d);
    reg_sel = sel; reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(logic [14:0] bits);
    @(negedge clk); irq_req = irq_req | bits;
    @(negedge clk); irq_req = irq_req & ~bits;
  endtask

  task automatic accept();
    @(negedge clk); vec_ready = 1'b1;
    @(negedge clk); vec_ready = 1'b0;
  endtask

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(0, 3'd0, r); chk("R1 primary mask", r, 8'hFF);
    rd(1, 3'd0, r); chk("R1 secondary mask", r, 8'hFF);
    rd(0, 3'd3, r); chk("R1 primary pending", r, 8'h00);
    rd(1, 3'd4, r); chk("R1 secondary in-service", r, 8'h00);
    chk("R1 valid low", {7'd0, vec_valid}, 8'h00);
    // R5 nothing before both bases written
    wr(0, 3'd0, 8'h00); wr(1, 3'd0, 8'h00);
    pulse(15'h0001);
    chk("R5 no delivery unarmed", {7'd0, vec_valid}, 8'h00);
    rd(0, 3'd3, r); chk("R2 pending recorded", r, 8'h01);
    wr(0, 3'd1, 8'd32);
    chk("R5 one base only", {7'd0, vec_valid}, 8'h00);
    wr(1, 3'd1, 8'd40);
    chk("R5 armed valid", {7'd0, vec_valid}, 8'h01);
    chk("R4 vector line0", vec_data, 8'd32);
    rd(1, 3'd1, r); chk("R9 base readback", r, 8'd40);
    rd(0, 3'd2, r); chk("R9 ack reads zero", r, 8'h00);
    // R11 hold under back-pressure
    repeat (3) @(negedge clk);
    chk("R11 valid held", {7'd0, vec_valid}, 8'h01);
    accept();
    chk("R6 valid falls", {7'd0, vec_valid}, 8'h00);
    rd(0, 3'd4, r); chk("R6 in-service set", r, 8'h01);
    rd(0, 3'd3, r); chk("R6 pending cleared", r, 8'h00);
    wr(0, 3'd2, 8'h00);
    rd(0, 3'd4, r); chk("R7 ack clears", r, 8'h00);
    // table walk: R4 / R10 per line
    for (int i = 0; i < 8; i++) begin
      pulse(15'(1) << TBL[i][15:8]);
      chk("R10 line raises valid", {7'd0, vec_valid}, 8'h01);
      chk("R4 vector", vec_data, TBL[i][7:0]);
      accept();
      chk("R6 valid after take", {7'd0, vec_valid}, 8'h00);
      wr(0, 3'd2, 8'h00);
      if (TBL[i][16]) wr(1, 3'd2, 8'h00);
      chk("R7 idle after ack", {7'd0, vec_valid}, 8'h00);
    end
    // R3 priority within primary
    pulse(15'h0012);
    chk("R3 lowest wins", vec_data, 8'd33);
    accept(); wr(0, 3'd2, 8'h00);
    chk("R3 next line", vec_data, 8'd37);
    accept(); wr(0, 3'd2, 8'h00);
    // R3 cascade ranks above line 3; R8 both acks needed
    pulse(15'h0084);
    chk("R3 cascade over line3", vec_data, 8'd40);
    accept(); wr(0, 3'd2, 8'h00);
    chk("R8 blocked after primary ack", {7'd0, vec_valid}, 8'h00);
    wr(1, 3'd2, 8'h00);
    chk("R8 resumes after both", vec_data, 8'd35);
    accept(); wr(0, 3'd2, 8'h00);
    // R2 masked line
    wr(0, 3'd0, 8'h20);
    pulse(15'h0010);
    chk("R2 masked no valid", {7'd0, vec_valid}, 8'h00);
    rd(0, 3'd3, r); chk("R2 masked pending", r, 8'h20);
    wr(0, 3'd0, 8'h00);
    chk("R2 unmasked delivers", vec_data, 8'd37);
    accept(); wr(0, 3'd2, 8'h00);
    // R8 secondary: ack secondary first
    pulse(15'h0900);
    chk("R8 secondary vector", vec_data, 8'd41);
    accept(); wr(1, 3'd2, 8'h00);
    chk("R8 primary still busy", {7'd0, vec_valid}, 8'h00);
    rd(0, 3'd4, r); chk("R8 primary cascade in service", r, 8'h04);
    rd(0, 3'd3, r); chk("R9 cascade level pending", r, 8'h04);
    wr(0, 3'd2, 8'h00);
    chk("R8 second secondary line", vec_data, 8'd44);
    accept(); wr(0, 3'd2, 8'h00); wr(1, 3'd2, 8'h00);
    // R6 blocking while in service
    pulse(15'h0001); accept();
    pulse(15'h0002);
    chk("R6 blocked until ack", {7'd0, vec_valid}, 8'h00);
    wr(0, 3'd2, 8'h00);
    chk("R6 delivers after ack", vec_data, 8'd33);
    accept(); wr(0, 3'd2, 8'h00);
    // R2 secondary mask
    wr(1, 3'd0, 8'hFF);
    pulse(15'h0200);
    chk("R2 secondary masked", {7'd0, vec_valid}, 8'h00);
    rd(1, 3'd3, r); chk("R2 secondary pending", r, 8'h04);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule